// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM whose read and write pipelines have the same depth. A write and a read can therefore follow each other on every clock with no idle cycle between them. The word is four 9-bit byte lanes. Every input is sampled on the rising clock edge, and only when the active-low clock enable is asserted. When the clock enable is high, the whole block freezes: the address and burst logic, both pipeline stages and the output register all hold.

An access begins with a load cycle. On that cycle the load/advance control is low, the three chip selects match their select pattern, and the write-enable level fixes the direction. Advance cycles that follow step a two-bit counter through the aligned group of four words. The counter starts at the low address bits and keeps the direction chosen on the load cycle. Write data is taken two enabled edges after its address. Read data is registered two enabled edges after its address and is driven only while output enable is low. A full-size instance sets `ADDR_W` to 17.

The block has no valid/ready handshake. The memory accepts one address per enabled cycle and has no back-pressure; the clock enable is the only way to stall it. A stall holds both the address and the data phases.

Top module: `nbt_sram`

## Requirements
- R1: After reset, `dout_en` is low and `dout` is zero until a read has passed through the pipeline.
- R2: A load cycle starts an access only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination writes nothing, produces no read result, and ends any running burst.
- R3: A read loaded with address A places word A in the output register after the second enabled rising edge that follows the load edge.
- R4: An advance cycle (`ld_n`=1) during an active burst increments address bits [1:0] by one, wrapping from 3 to 0, keeps the upper bits, and repeats the direction of the load.
- R5: A write loaded with `we_n`=0 stores the `din` value present at the second enabled rising edge that follows its address edge.
- R6: `bw_n` is sampled on each address cycle, load or advance. Lane i is bits [9i+8:9i], so lane 0 is bits 8:0. A write updates lane i only when `bw_n[i]`=0 and leaves the other lanes unchanged.
- R7: A rising edge with `cen_n`=1 changes no stored word and no pipeline or output state, whatever the other inputs are.
- R8: Reads and writes may alternate on consecutive enabled cycles. A read returns every write whose address cycle came before its own.
- R9: `dout_en` equals (`oe_n`=0 AND a read result is held). `dout` is zero whenever `dout_en` is low.
- R10: Advance cycles that follow a deselecting load start no access and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the control and pipeline state |
| cen_n | input | 1 | Active-low clock enable |
| addr | input | ADDR_W | Word address, sampled on load cycles |
| ld_n | input | 1 | 0 = load a new address, 1 = advance the burst |
| we_n | input | 1 | 0 = write access on a load cycle |
| bw_n | input | LANES | Active-low byte-lane write enables |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Active-low output enable |
| din | input | LANES*LANE_W | Write data, taken in the data phase |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |

## Verification
Every result is due a fixed number of enabled edges after its address cycle. A read appears in the output register after the second enabled edge, and write data is taken at that same second edge. Edges with `cen_n` high do not count toward either delay. The bench drives inputs on the falling edge and runs an independent two-slot model of the pipeline at the same moment. It compares `dout_en` and `dout` at the next falling edge, so each expected value falls in the exact cycle it is due, including across stalls.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  typedef struct packed {
    logic vld;
    logic wr;
  } nbt_op_t;
endpackage

// File: rtl/nbt_ctrl.sv
module nbt_ctrl
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ld_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  output nbt_op_t           s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_ben
);
  localparam int HI_W = ADDR_W - 2;

  logic            sel;
  logic            act;
  logic            wr_q;
  logic [HI_W-1:0] hi_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_nx;

  assign sel    = !cs1_n && cs2 && !cs3_n;
  assign cnt_nx = cnt_q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      wr_q    <= 1'b0;
      hi_q    <= '0;
      cnt_q   <= '0;
      s1_op   <= '0;
      s1_addr <= '0;
      s1_ben  <= '0;
    end else if (en) begin
      if (!ld_n) begin
        act       <= sel;
        wr_q      <= !we_n;
        hi_q      <= addr[ADDR_W-1:2];
        cnt_q     <= addr[1:0];
        s1_op.vld <= sel;
        s1_op.wr  <= !we_n;
        s1_addr   <= addr;
        s1_ben    <= ~bw_n;
      end else if (act) begin
        cnt_q     <= cnt_nx;
        s1_op.vld <= 1'b1;
        s1_op.wr  <= wr_q;
        s1_addr   <= {hi_q, cnt_nx};
        s1_ben    <= ~bw_n;
      end else begin
        s1_op <= '0;
      end
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s1_ben)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ld_n && act) |=>
      (s1_op.vld && s1_addr[1:0] == 2'($past(s1_addr[1:0]) + 2'd1) &&
       s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  assert_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld_n && !sel) |=> !s1_op.vld);

  assert_idle_adv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ld_n && !act) |=> !s1_op.vld);
endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        ben,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (en && wr && ben[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (en && rd) rdata[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ld_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int WORD_W = LANES * LANE_W;

  logic              en;
  nbt_op_t           s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_ben, s2_ben;
  logic              wr_stb, rd_stb, rd_valid;
  logic [WORD_W-1:0] q;

  assign en = !cen_n;

  nbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .addr(addr), .ld_n(ld_n),
    .we_n(we_n), .bw_n(bw_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_ben(s1_ben)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op    <= '0;
      s2_addr  <= '0;
      s2_ben   <= '0;
      rd_valid <= 1'b0;
    end else if (en) begin
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_ben   <= s1_ben;
      rd_valid <= rd_stb;
    end
  end

  assign wr_stb = s2_op.vld && s2_op.wr;
  assign rd_stb = s2_op.vld && !s2_op.wr;

  nbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .en(en), .wr(wr_stb), .rd(rd_stb), .addr(s2_addr),
    .ben(s2_ben), .wdata(din), .rdata(q)
  );

  assign dout_en = !oe_n && rd_valid;
  assign dout    = dout_en ? q : '0;

  assert_rd_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s2_op.vld && !s2_op.wr) |=> rd_valid);

  assert_wr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s2_op.vld && s2_op.wr) |=> !rd_valid);

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(rd_valid) && $stable(s2_op) && $stable(s2_addr)));
endmodule

// File: tb/sim_nbt_sram.sv
module sim_nbt_sram;
  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int WW    = LN * LW;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] SEL = 3'b010; // {cs1_n, cs2, cs3_n}

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b1, ld_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] bw_n = '1;
  logic [WW-1:0] din = '0;
  logic [WW-1:0] dout;
  logic          dout_en;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [WW-1:0] m [DEPTH];
  logic          b_act = 0, b_wr = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;
  logic          p1v = 0, p1w = 0, p2v = 0, p2w = 0;
  logic [AW-1:0] p1a = '0, p2a = '0;
  logic [LN-1:0] p1b = '0, p2b = '0;
  logic          exp_v = 0;
  logic [WW-1:0] exp_q = '0;

  always #(CLK_P/2) clk = ~clk;

  nbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .addr(addr), .ld_n(ld_n),
    .we_n(we_n), .bw_n(bw_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic model_edge();
    if (cen_n) return;
    if (p2v && p2w) begin
      for (int l = 0; l < LN; l++)
        if (p2b[l]) m[p2a][l*LW +: LW] = din[l*LW +: LW];
      exp_v = 0;
    end else if (p2v) begin
      exp_q = m[p2a];
      exp_v = 1;
    end else begin
      exp_v = 0;
    end
    p2v = p1v; p2w = p1w; p2a = p1a; p2b = p1b;
    if (!ld_n) begin
      b_act = ({cs1_n, cs2, cs3_n} == SEL);
      b_wr = !we_n; b_base = addr; b_cnt = addr[1:0];
      p1v = b_act; p1w = b_wr; p1a = addr; p1b = ~bw_n;
    end else if (b_act) begin
      b_cnt = b_cnt + 2'd1;
      p1v = 1; p1w = b_wr; p1a = {b_base[AW-1:2], b_cnt}; p1b = ~bw_n;
    end else begin
      p1v = 0;
    end
  endtask

  task automatic check(input string tag);
    logic want_en;
    want_en = !oe_n && exp_v;
    n_chk++;
    if (dout_en !== want_en) begin
      n_err++;
      $display("FAIL R9 (%s): dout_en=%b expected %b", tag, dout_en, want_en);
    end
    n_chk++;
    if (want_en) begin
      if (dout !== exp_q) begin
        n_err++;
        $display("FAIL %s: dout=%h expected %h", tag, dout, exp_q);
      end
    end else if (dout !== '0) begin
      n_err++;
      $display("FAIL R9 (%s): dout=%h expected 0", tag, dout);
    end
  endtask

  // one clock: drive at falling edge, model the rising edge, check at next falling edge
  task automatic cyc(input logic c_n, input logic ld, input logic we,
                     input logic [AW-1:0] a, input logic [LN-1:0] bw,
                     input logic [2:0] cs, input logic oe, input string tag);
    cen_n = c_n; ld_n = ld; we_n = we; addr = a; bw_n = bw;
    {cs1_n, cs2, cs3_n} = cs; oe_n = oe;
    din = {$urandom, $urandom};
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic nop(input string tag);
    cyc(1'b0, 1'b0, 1'b1, '0, '1, 3'b110, 1'b0, tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    oe_n = 1'b0;
    @(negedge clk);
    check("R1"); // nothing read yet: dout_en low, dout zero

    // R5: fill every word with full-lane writes
    for (int a = 0; a < DEPTH; a++) cyc(0, 0, 0, AW'(a), '0, SEL, 0, "R5");
    nop("R5"); nop("R5");
    for (int a = 0; a < 8; a++) cyc(0, 0, 1, AW'(a), '1, SEL, 0, "R3");
    nop("R3"); nop("R3");

    // R6 and R4: masked write burst starting at offset 2, then read back wrapped
    cyc(0, 0, 0, AW'(8'h26), 4'b1110, SEL, 0, "R6");
    cyc(0, 1, 1, '0, 4'b0101, 3'b101, 0, "R6");
    cyc(0, 1, 1, '0, 4'b1011, 3'b101, 0, "R6");
    cyc(0, 1, 1, '0, 4'b0111, 3'b101, 0, "R6");
    cyc(0, 0, 1, AW'(8'h27), '1, SEL, 0, "R4");
    cyc(0, 1, 0, '0, '0, 3'b000, 0, "R4");
    cyc(0, 1, 0, '0, '0, 3'b000, 0, "R4");
    cyc(0, 1, 0, '0, '0, 3'b000, 0, "R4");
    cyc(0, 1, 0, '0, '0, 3'b000, 0, "R4");
    nop("R4"); nop("R4");

    // R2: every non-selecting chip-select pattern on a write load
    for (int c = 0; c < 8; c++)
      if (3'(c) != SEL) cyc(0, 0, 0, AW'(8'h40 + c), '0, 3'(c), 0, "R2");
    nop("R2"); nop("R2");
    for (int c = 0; c < 8; c++) cyc(0, 0, 1, AW'(8'h40 + c), '1, SEL, 0, "R2");
    nop("R2"); nop("R2");

    // R10: advances after a deselecting load
    cyc(0, 0, 0, AW'(8'h50), '0, 3'b011, 0, "R10");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, '0, '0, SEL, 0, "R10");
    nop("R10"); nop("R10");
    for (int a = 0; a < 4; a++) cyc(0, 0, 1, AW'(8'h50 + a), '1, SEL, 0, "R10");
    nop("R10"); nop("R10");

    // R7: stalls inside both read and write pipelines
    cyc(0, 0, 0, AW'(8'h60), '0, SEL, 0, "R7");
    cyc(0, 0, 1, AW'(8'h61), '1, SEL, 0, "R7");
    for (int k = 0; k < 4; k++)
      cyc(1, 1'($urandom), 1'($urandom), AW'($urandom), 4'($urandom), 3'($urandom), 0, "R7");
    cyc(0, 0, 1, AW'(8'h60), '1, SEL, 0, "R7");
    for (int k = 0; k < 3; k++)
      cyc(1, 0, 0, AW'(8'h61), '0, SEL, 0, "R7");
    nop("R7"); nop("R7"); nop("R7");

    // R8: alternate write and read of the same word every cycle
    for (int k = 0; k < 16; k++) begin
      cyc(0, 0, 0, AW'(8'h70 + k), 4'($urandom), SEL, 0, "R8");
      cyc(0, 0, 1, AW'(8'h70 + k), '1, SEL, 0, "R8");
    end
    nop("R8"); nop("R8");

    // R9: output enable high hides a valid read
    cyc(0, 0, 1, AW'(8'h71), '1, SEL, 1, "R9");
    cyc(0, 0, 1, AW'(8'h72), '1, SEL, 1, "R9");
    cyc(0, 0, 1, '0, '1, 3'b110, 1, "R9");
    cyc(0, 0, 1, '0, '1, 3'b110, 0, "R9");
    nop("R9");

    // random mix over a small window so reads hit recent writes
    for (int k = 0; k < 4000; k++) begin
      logic [AW-1:0] ra;
      logic [2:0] cs;
      ra = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 16);
      cs = ($urandom % 8 == 0) ? 3'($urandom) : SEL;
      cyc(1'($urandom % 8 == 0), 1'($urandom % 4 == 0), 1'($urandom),
          ra, 4'($urandom), cs, 1'($urandom % 6 == 0), "R8");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: cycles=200000 expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule